// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a synchronous static memory with 36-bit words. Each word is split into four 9-bit lanes. It accepts a read or a write command on any enabled rising clock edge, with no idle cycle when the bus changes direction. Read data flows straight from the array to the output in the cycle after the command edge. Write data arrives one enabled edge after its command, while the data bus is released.

A single loaded address can start a burst of up to four beats. The two low address bits step in linear or interleaved order. A clock enable freezes the whole block, so a host can pace a burst without losing its place. Three chip enables qualify every load. An asynchronous output enable gates only whether the bus is driven. A sleep input takes the block through a two-edge entry and a two-edge recovery, and keeps the stored words throughout.

The data bus is split into `dIn`, `dOut` and `dOutEn`. A pad ring outside this block combines them into one bidirectional bus.

Top module: `zbtSram`

## Requirements
- R1: All inputs are acted on only at rising edges where `clkEnN` is low. A command presented at an edge with `clkEnN` high is ignored.
- R2: An edge with `clkEnN` high leaves every internal state unchanged, including a pending write and the beat position. A stalled burst resumes on the next address in its sequence, and write data is taken at the next enabled edge.
- R3: A load is accepted only when `chipSel0N` is low, `chipSel1` is high and `chipSel2N` is low. Any other combination deselects the block: no drive and no write.
- R4: With `advLdN` low, a load starts a new command: `wrEnN` low means write. With `advLdN` high, the burst advances one beat and keeps the type of its load. An advance while deselected stays idle.
- R5: When `burstInterleave` is 0 at the load, beat k uses the low address bits (start + k) mod 4. The upper bits stay fixed.
- R6: When `burstInterleave` is 1 at the load, beat k uses the low address bits start XOR k.
- R7: Write data on `dIn` is captured at the first enabled edge after the write command or beat. `dOutEn` stays low in that cycle.
- R8: Lane i is bits 9i+8..9i. A lane is written only when `byteWrN[i]` is low at its command or beat. The other lanes keep their contents.
- R9: Read data is valid in the cycle that follows the edge registering the read. Reads and writes may alternate on consecutive edges with no idle cycle.
- R10: A read of a word whose write data has been captured but not yet committed returns the new lanes merged over the old word.
- R11: `outEnN` high forces `dOutEn` low at once, with no clock edge involved.
- R12: A high `sleepReq` at two consecutive enabled edges enters sleep. Leaving sleep takes two low edges, and then one more recovery edge. Commands at any edge with `sleepReq` high, during entry, while asleep or during recovery are ignored. Stored words are kept.
- R13: After reset the block is idle and does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset of the control state |
| clkEnN | input | 1 | Active-low clock enable; high freezes all state |
| addr | input | AW | Word address, sampled at loads |
| chipSel0N | input | 1 | Chip enable, active low |
| chipSel1 | input | 1 | Chip enable, active high |
| chipSel2N | input | 1 | Chip enable, active low |
| wrEnN | input | 1 | Low selects write at a load |
| byteWrN | input | LANES | Active-low lane write selects |
| advLdN | input | 1 | Low loads a new address; high advances the burst |
| burstInterleave | input | 1 | Beat order at load: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| sleepReq | input | 1 | Sleep request |
| dIn | input | LANE_W*LANES | Write data |
| dOut | output | LANE_W*LANES | Read data, zero when not driven |
| dOutEn | output | 1 | Bus drive enable |

## Verification
Two functions can fall in the same cycle. One edge can capture the data of an earlier write and also register a read of the same word, so the read cycle must see the write still parked in the buffer. The bench provokes this with lane-masked writes followed at once by loads of the same address, and with stalls placed over a write data phase. It judges every cycle against a behavioural model that applies the write to its memory at the capture edge.

// File: rtl/zbtSramPkg.sv
package zbtSramPkg;

  typedef struct packed {
    logic tick;     // enabled clock edge
    logic capture;  // current cycle is a write data phase
    logic readOut;  // current cycle returns read data
  } sramStrobe_t;

  typedef enum logic [2:0] {
    SLP_AWAKE,
    SLP_ENTER,
    SLP_ASLEEP,
    SLP_WAKE1,
    SLP_WAKE2
  } sleepState_t;

  function automatic logic [1:0] beatLow(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zbtSramCtrl.sv
module zbtSramCtrl
  import zbtSramPkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic [AW-1:0]    addr,
  input  logic             chipSel0N,
  input  logic             chipSel1,
  input  logic             chipSel2N,
  input  logic             wrEnN,
  input  logic [LANES-1:0] byteWrN,
  input  logic             advLdN,
  input  logic             burstInterleave,
  input  logic             sleepReq,
  output sramStrobe_t      strobe,
  output logic [AW-1:0]    opAddr,
  output logic [LANES-1:0] opMask
);

  logic             opValid;
  logic             opWrite;
  logic             opInter;
  logic [AW-1:0]    baseAddr;
  logic [1:0]       beat;
  logic [LANES-1:0] maskQ;
  sleepState_t      slp;
  sleepState_t      slpNext;
  logic             selected;
  logic             cmdAllowed;

  assign selected   = ~chipSel0N & chipSel1 & ~chipSel2N;
  assign cmdAllowed = (slp == SLP_AWAKE) & ~sleepReq;

  always_comb begin
    slpNext = slp;
    unique case (slp)
      SLP_AWAKE:  slpNext = sleepReq ? SLP_ENTER  : SLP_AWAKE;
      SLP_ENTER:  slpNext = sleepReq ? SLP_ASLEEP : SLP_AWAKE;
      SLP_ASLEEP: slpNext = sleepReq ? SLP_ASLEEP : SLP_WAKE1;
      SLP_WAKE1:  slpNext = sleepReq ? SLP_ASLEEP : SLP_WAKE2;
      SLP_WAKE2:  slpNext = sleepReq ? SLP_ASLEEP : SLP_AWAKE;
      default:    slpNext = SLP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid  <= 1'b0;
      opWrite  <= 1'b0;
      opInter  <= 1'b0;
      baseAddr <= '0;
      beat     <= '0;
      maskQ    <= '0;
      slp      <= SLP_AWAKE;
    end else if (!clkEnN) begin
      slp <= slpNext;
      if (!cmdAllowed) begin
        opValid <= 1'b0;
      end else if (!advLdN) begin
        opValid <= selected;
        if (selected) begin
          baseAddr <= addr;
          beat     <= '0;
          opWrite  <= ~wrEnN;
          opInter  <= burstInterleave;
          maskQ    <= ~byteWrN;
        end
      end else if (opValid) begin
        beat  <= beat + 2'd1;
        maskQ <= ~byteWrN;
      end
    end
  end

  assign opAddr = {baseAddr[AW-1:2], beatLow(baseAddr[1:0], beat, opInter)};
  assign opMask = maskQ;

  assign strobe.tick    = ~clkEnN;
  assign strobe.capture = opValid & opWrite;
  assign strobe.readOut = opValid & ~opWrite;

endmodule

// File: rtl/zbtSramData.sv
module zbtSramData
  import zbtSramPkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sramStrobe_t             strobe,
  input  logic [AW-1:0]           opAddr,
  input  logic [LANES-1:0]        opMask,
  input  logic [LANE_W*LANES-1:0] dIn,
  input  logic                    outEnN,
  output logic [LANE_W*LANES-1:0] dOut,
  output logic                    dOutEn
);

  localparam int WORD_W = LANE_W * LANES;
  localparam int DEPTH  = 1 << AW;

  logic              wbufValid;
  logic [AW-1:0]     wbufAddr;
  logic [WORD_W-1:0] wbufData;
  logic [LANES-1:0]  wbufMask;
  logic [WORD_W-1:0] rdWord;
  logic              wbufHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbufValid <= 1'b0;
      wbufAddr  <= '0;
      wbufData  <= '0;
      wbufMask  <= '0;
    end else if (strobe.tick) begin
      wbufValid <= strobe.capture;
      if (strobe.capture) begin
        wbufAddr <= opAddr;
        wbufData <= dIn;
        wbufMask <= opMask;
      end
    end
  end

  assign wbufHit = wbufValid & (wbufAddr == opAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.tick && wbufValid && wbufMask[g])
        laneMem[wbufAddr] <= wbufData[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = (wbufHit && wbufMask[g])
                                        ? wbufData[g*LANE_W +: LANE_W]
                                        : laneMem[opAddr];
  end

  assign dOutEn = strobe.readOut & ~outEnN;
  assign dOut   = dOutEn ? rdWord : '0;

endmodule

// File: rtl/zbtSram.sv
module zbtSram
  import zbtSramPkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic [AW-1:0]           addr,
  input  logic                    chipSel0N,
  input  logic                    chipSel1,
  input  logic                    chipSel2N,
  input  logic                    wrEnN,
  input  logic [LANES-1:0]        byteWrN,
  input  logic                    advLdN,
  input  logic                    burstInterleave,
  input  logic                    outEnN,
  input  logic                    sleepReq,
  input  logic [LANE_W*LANES-1:0] dIn,
  output logic [LANE_W*LANES-1:0] dOut,
  output logic                    dOutEn
);

  sramStrobe_t      strobeW;
  logic [AW-1:0]    opAddrW;
  logic [LANES-1:0] opMaskW;

  zbtSramCtrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr),
    .chipSel0N(chipSel0N), .chipSel1(chipSel1), .chipSel2N(chipSel2N),
    .wrEnN(wrEnN), .byteWrN(byteWrN), .advLdN(advLdN),
    .burstInterleave(burstInterleave), .sleepReq(sleepReq),
    .strobe(strobeW), .opAddr(opAddrW), .opMask(opMaskW)
  );

  zbtSramData #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobeW), .opAddr(opAddrW),
    .opMask(opMaskW), .dIn(dIn), .outEnN(outEnN), .dOut(dOut),
    .dOutEn(dOutEn)
  );

endmodule

// File: rtl/zbtSramChk.sv
module zbtSramChk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              chipSel0N,
  input logic              chipSel1,
  input logic              chipSel2N,
  input logic              advLdN,
  input logic              outEnN,
  input logic              sleepReq,
  input logic              captureQ,
  input logic              dOutEn,
  input logic [WORD_W-1:0] dOut
);

  // R11: output enable gates the drive without a clock edge
  always_comb begin
    if (rstN && outEnN) begin
      a_r11_oe_gate: assert (!dOutEn);
    end
  end

  // R7: bus released during a write data phase
  a_r7_capture_hiz: assert property (@(posedge clk) disable iff (!rstN)
    captureQ |-> !dOutEn);

  // R3: a deselecting load leaves the bus undriven
  a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && !(!chipSel0N && chipSel1 && !chipSel2N)) |=> !dOutEn);

  // R12: an edge with sleep requested accepts no read
  a_r12_sleep_block: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && sleepReq) |=> !dOutEn);

  // R2: a stalled edge changes nothing visible
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !outEnN) |=> (outEnN || ($stable(dOut) && $stable(dOutEn))));

  // R13: idle at the first edge after reset
  a_r13_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dOutEn);

endmodule

bind zbtSram zbtSramChk #(.WORD_W(LANE_W*LANES)) chk_i (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipSel0N(chipSel0N),
  .chipSel1(chipSel1), .chipSel2N(chipSel2N), .advLdN(advLdN),
  .outEnN(outEnN), .sleepReq(sleepReq), .captureQ(strobeW.capture),
  .dOutEn(dOutEn), .dOut(dOut)
);

// File: tb/zbtSram_tb_top.sv
module zbtSram_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0;
  logic [5:0]  addr = '0;
  logic        chipSel0N = 1'b0;
  logic        chipSel1 = 1'b0;
  logic        chipSel2N = 1'b0;
  logic        wrEnN = 1'b1;
  logic [3:0]  byteWrN = 4'hF;
  logic        advLdN = 1'b0;
  logic        burstInterleave = 1'b0;
  logic        outEnN = 1'b0;
  logic        sleepReq = 1'b0;
  logic [35:0] dIn = '0;
  logic [35:0] dOut;
  logic        dOutEn;

  int    checks = 0;
  int    fails = 0;
  bit    checking = 0;
  bit    done = 0;
  string curReq = "R13";

  always #4 clk = ~clk;

  zbtSram dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr),
    .chipSel0N(chipSel0N), .chipSel1(chipSel1), .chipSel2N(chipSel2N),
    .wrEnN(wrEnN), .byteWrN(byteWrN), .advLdN(advLdN),
    .burstInterleave(burstInterleave), .outEnN(outEnN), .sleepReq(sleepReq),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  // ---------------- behavioural reference ----------------
  logic [35:0] mMem [64];
  bit          mValid = 0;
  bit          mWrite = 0;
  bit          mInter = 0;
  int          mBase = 0;
  int          mBeat = 0;
  logic [3:0]  mMask = '0;
  int          mSlp = 0; // 0 awake 1 entering 2 asleep 3 wake1 4 wake2

  function automatic int effAddr();
    int lo;
    lo = mInter ? ((mBase % 4) ^ mBeat) : (((mBase % 4) + mBeat) % 4);
    return (mBase / 4) * 4 + lo;
  endfunction

  always @(posedge clk) begin
    if (rstN && !clkEnN) begin
      int  a;
      bit  allowed;
      bit  sel;
      a = effAddr();
      if (mValid && mWrite)
        for (int l = 0; l < 4; l++)
          if (mMask[l]) mMem[a][l*9 +: 9] = dIn[l*9 +: 9];
      allowed = (mSlp == 0) && !sleepReq;
      sel = !chipSel0N && chipSel1 && !chipSel2N;
      if (!allowed) mValid = 0;
      else if (!advLdN) begin
        mValid = sel;
        if (sel) begin
          mBase = int'(addr); mBeat = 0; mWrite = !wrEnN;
          mInter = burstInterleave; mMask = ~byteWrN;
        end
      end else if (mValid) begin
        mBeat = (mBeat + 1) % 4;
        mMask = ~byteWrN;
      end
      case (mSlp)
        0: mSlp = sleepReq ? 1 : 0;
        1: mSlp = sleepReq ? 2 : 0;
        2: mSlp = sleepReq ? 2 : 3;
        3: mSlp = sleepReq ? 2 : 4;
        default: mSlp = sleepReq ? 2 : 0;
      endcase
    end
  end

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (checking && !done) begin
      bit expEn;
      expEn = mValid && !mWrite && !outEnN;
      check(curReq, {35'd0, dOutEn}, {35'd0, expEn});
      if (expEn) check(curReq, dOut, mMem[effAddr()]);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [35:0] pat(input int a, input int salt);
    return {4'h5, 8'(a), 24'(salt * 24'h3a5c7 + a * 24'h111)};
  endfunction

  task automatic loadCmd(input int a, input bit wr, input logic [3:0] bwN,
                         input bit inter, input logic [35:0] d);
    clkEnN = 0; advLdN = 0; chipSel0N = 0; chipSel1 = 1; chipSel2N = 0;
    addr = 6'(a); wrEnN = !wr; byteWrN = bwN; burstInterleave = inter; dIn = d;
    @(negedge clk);
  endtask

  task automatic loadSel(input int a, input logic c0N, input logic c1, input logic c2N,
                         input logic [35:0] d);
    clkEnN = 0; advLdN = 0; chipSel0N = c0N; chipSel1 = c1; chipSel2N = c2N;
    addr = 6'(a); wrEnN = 0; byteWrN = 4'h0; dIn = d;
    @(negedge clk);
  endtask

  task automatic advCmd(input logic [3:0] bwN, input logic [35:0] d);
    clkEnN = 0; advLdN = 1; byteWrN = bwN; dIn = d;
    @(negedge clk);
  endtask

  task automatic idleCmd(input logic [35:0] d);
    clkEnN = 0; advLdN = 0; chipSel1 = 0; wrEnN = 1; dIn = d;
    @(negedge clk);
  endtask

  task automatic stallCmd(input logic [35:0] d);
    // a full load command is presented but must be ignored (R1)
    clkEnN = 1; advLdN = 0; chipSel0N = 0; chipSel1 = 1; chipSel2N = 0;
    addr = 6'd63; wrEnN = 0; byteWrN = 4'h0; dIn = d;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [35:0] dPrev;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R13";
    check("R13", {35'd0, dOutEn}, 36'd0);
    checking = 1;

    // fill with linear write bursts (R5, R7)
    curReq = "R5";
    dPrev = '0;
    for (int w = 0; w < 64; w++) begin
      if (w % 4 == 0) loadCmd(w, 1, 4'h0, 0, dPrev);
      else advCmd(4'h0, dPrev);
      dPrev = pat(w, 1);
    end
    idleCmd(dPrev);

    // linear read burst, then read/write turnaround with no idle (R5, R9)
    curReq = "R9";
    loadCmd(5, 0, 4'hF, 0, '0);
    check("R9", dOut, pat(5, 1));
    advCmd(4'hF, '0);
    check("R5", dOut, pat(6, 1));
    advCmd(4'hF, '0);
    advCmd(4'hF, '0);
    check("R5", dOut, pat(4, 1));
    loadCmd(12, 1, 4'h0, 0, '0);
    loadCmd(13, 0, 4'hF, 0, pat(12, 2));
    loadCmd(12, 0, 4'hF, 0, '0);
    check("R9", dOut, pat(12, 2));
    idleCmd('0);

    // interleaved read from low bits 10 and write burst from 11 (R6)
    curReq = "R6";
    loadCmd(10, 0, 4'hF, 1, '0);
    advCmd(4'hF, '0);
    check("R6", dOut, pat(11, 1));
    advCmd(4'hF, '0);
    check("R6", dOut, pat(8, 1));
    advCmd(4'hF, '0);
    loadCmd(7, 1, 4'h0, 1, '0);
    advCmd(4'h0, pat(7, 3));
    advCmd(4'h0, pat(6, 3));
    advCmd(4'h0, pat(5, 3));
    loadCmd(4, 0, 4'hF, 0, pat(4, 3));
    advCmd(4'hF, '0);
    advCmd(4'hF, '0);
    check("R6", dOut, pat(6, 3));
    advCmd(4'hF, '0);
    idleCmd('0);

    // lane masked write (R8)
    curReq = "R8";
    loadCmd(20, 1, 4'b1010, 0, '0);
    idleCmd(36'hfff_fff_fff);
    loadCmd(20, 0, 4'hF, 0, '0);
    check("R8", dOut, {pat(20, 1)[35:27], 9'h1ff, pat(20, 1)[17:9], 9'h1ff});
    idleCmd('0);

    // read of a word whose data is parked in the write buffer (R10)
    curReq = "R10";
    loadCmd(30, 1, 4'b0011, 0, '0);
    loadCmd(30, 0, 4'hF, 0, 36'h0ab_cde_f12);
    check("R10", dOut, {9'h0ab & 9'h1ff, 9'h0cd << 0 | 9'(36'h0ab_cde_f12 >> 18), pat(30, 1)[17:0]} & 36'h0 | {36'h0ab_cde_f12 >> 18 << 18 | 36'(pat(30, 1)[17:0])});
    advCmd(4'hF, '0);
    loadCmd(30, 1, 4'b1110, 0, '0);
    loadCmd(30, 0, 4'hF, 0, 36'h123_456_789);
    idleCmd('0);

    // stalls mid read burst and over a write data phase (R1, R2)
    curReq = "R2";
    loadCmd(40, 0, 4'hF, 0, '0);
    curReq = "R1";
    stallCmd('1);
    check("R2", dOut, pat(40, 1));
    curReq = "R2";
    advCmd(4'hF, '0);
    stallCmd('1);
    stallCmd('0);
    check("R2", dOut, pat(41, 1));
    advCmd(4'hF, '0);
    check("R2", dOut, pat(42, 1));
    loadCmd(44, 1, 4'h0, 0, '0);
    stallCmd(36'h111_111_111);
    stallCmd(36'h222_222_222);
    loadCmd(44, 0, 4'hF, 0, pat(44, 7));
    check("R2", dOut, pat(44, 7));
    loadCmd(63, 0, 4'hF, 0, '0);
    check("R1", dOut, pat(63, 1));
    idleCmd('0);

    // deselect combinations and advance while deselected (R3, R4)
    curReq = "R3";
    loadSel(50, 1, 1, 0, '0);
    loadSel(50, 0, 0, 0, 36'h0aa_aaa_aaa);
    loadSel(50, 0, 1, 1, 36'h0bb_bbb_bbb);
    curReq = "R4";
    advCmd(4'h0, 36'h0cc_ccc_ccc);
    advCmd(4'h0, 36'h0dd_ddd_ddd);
    check("R4", {35'd0, dOutEn}, 36'd0);
    loadCmd(50, 0, 4'hF, 0, 36'h0ee_eee_eee);
    check("R3", dOut, pat(50, 1));
    advCmd(4'hF, '0);
    check("R4", dOut, pat(51, 1));
    idleCmd('0);

    // asynchronous output enable (R11)
    curReq = "R11";
    loadCmd(8, 0, 4'hF, 0, '0);
    check("R9", {35'd0, dOutEn}, 36'd1);
    outEnN = 1;
    #1;
    check("R11", {35'd0, dOutEn}, 36'd0);
    outEnN = 0;
    #1;
    check("R11", dOut, pat(8, 1));
    outEnN = 1;
    advCmd(4'hF, '0);
    outEnN = 0;
    idleCmd('0);

    // sleep entry, recovery window and retention (R12)
    curReq = "R12";
    sleepReq = 1;
    loadCmd(60, 1, 4'h0, 0, '0);
    loadCmd(60, 0, 4'hF, 0, 36'h0f0_f0f_0f0);
    check("R12", {35'd0, dOutEn}, 36'd0);
    idleCmd('0);
    idleCmd('0);
    sleepReq = 0;
    loadCmd(61, 1, 4'h0, 0, '0);
    loadCmd(60, 1, 4'h0, 0, 36'h0f1_f1f_1f1);
    loadCmd(60, 0, 4'hF, 0, 36'h0f2_f2f_2f2);
    check("R12", {35'd0, dOutEn}, 36'd0);
    loadCmd(60, 0, 4'hF, 0, 36'h0f3_f3f_3f3);
    check("R12", dOut, pat(60, 1));
    loadCmd(61, 0, 4'hF, 0, '0);
    check("R12", dOut, pat(61, 1));
    idleCmd('0);
    idleCmd('0);

    finishRun();
  end

endmodule